// File: doc/BRIEF.md
# Page Load Write Sequencer with Toggle Status

This block gathers byte writes aimed at one page of a small nonvolatile array and commits them as one programming operation. The first accepted write opens a page and records its page index, taken from the address bits above the in-page offset. Each later accepted write to the same page stores its byte and restarts a load window. When the window runs out with no further write, the block raises a one-cycle commit request and enters a busy period of fixed length. At the end of that period the buffered bytes are merged into the array.

During the busy period a read does not return array data. It returns a status byte whose bit 6 changes value on every read, so software can poll for completion. An active-low write-enable pin gates every write. Driving it high while a page is open cancels that page.

The controller is a three-state machine. IDLE becomes LOAD on the first accepted write (the open transition). LOAD stays in LOAD when a same-page write arrives (extend). LOAD returns to IDLE when the write-enable pin goes high (abort). LOAD moves to PROG when the window runs out (expire). PROG returns to IDLE when the programming counter reaches zero (finish). The window length and the programming length are parameters counted in clock cycles.

Top module: `page_load_ctrl`

## Requirements
- R1: A write is accepted when `wr_en`=1 and `wr_en_n_pin`=0 while not busy. In IDLE it opens a page whose index is `wr_addr[ADDR_W-1:OFF_W]`, and its byte goes to offset `wr_addr[OFF_W-1:0]`.
- R2: Each accepted same-page write restarts the window. If the last accepted write is sampled at edge k, `busy` and `commit` are first high after edge k+LOAD_CYC. `commit` is high for that one cycle only.
- R3: While a page is open, a write whose page index differs from the open page stores nothing and does not restart the window.
- R4: `busy` stays high for exactly PROG_CYC cycles. A read issued in the first cycle after `busy` falls returns the newly programmed data.
- R5: While `busy` is high, the result of a read is a status byte with every bit zero except bit 6. Bit 6 is 0 for the first read of a programming period and inverts on each later read.
- R6: When not busy, a read of `rd_addr` shows the array byte on `rd_data` one cycle later. `rd_data` holds its value between reads.
- R7: If `wr_en_n_pin` is 1 in any cycle while a page is open, the page is dropped: no programming follows and the array is unchanged.
- R8: While `wr_en_n_pin` is held at 1, no write is accepted and the array never changes.
- R9: Writes presented while `busy` is high are discarded. They open no page and change no array byte.
- R10: Array bytes at offsets not written during a page load keep their previous contents. If one offset is written several times, the last value is the one programmed.
- R11: After reset, `busy`=0, `commit`=0, `rd_data`=0 and every array byte reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write request |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 8 | Write byte value |
| wr_en_n_pin | input | 1 | Active-low write permission; high cancels an open page |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 8 | Read result, registered |
| busy | output | 1 | Programming in progress |
| commit | output | 1 | One-cycle pulse when programming begins |

## Verification
Several properties are checked on every cycle:
- `commit` is a single-cycle pulse and falls inside `busy`.
- Raising the pin during LOAD always leads back to IDLE.
- The open page index does not move while loading.
- The buffered bytes are frozen during PROG.
- The status byte toggles between back-to-back busy reads and has every other bit cleared.

Only the bench scenarios can show the remaining behaviour:
- Exact window and busy lengths counted from the last write.
- Merging of partial pages into the array.
- That off-page, cancelled, pin-blocked and busy-time writes leave the array untouched.

The bench shows these by reading the whole array back after each scenario.

// File: rtl/plt_pkg.sv
package plt_pkg;
    localparam int BYTE_W     = 8;
    localparam int TOGGLE_BIT = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } plt_state_e;
endpackage

// File: rtl/plt_timer.sv
module plt_timer #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dec,
    output logic zero
);
    localparam int W = (LEN < 2) ? 1 : $clog2(LEN + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= W'(LEN - 1);
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= W'(LEN - 1)); // R2
endmodule

// File: rtl/plt_pagebuf.sv
module plt_pagebuf #(
    parameter int OFF_W = 5
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clr,
    input  logic                                  we,
    input  logic [OFF_W-1:0]                      idx,
    input  logic [plt_pkg::BYTE_W-1:0]            din,
    output logic [(1<<OFF_W)-1:0][plt_pkg::BYTE_W-1:0] data,
    output logic [(1<<OFF_W)-1:0]                 mask
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
            mask <= '0;
        end else begin
            if (clr)
                mask <= '0;
            if (we) begin
                data[idx] <= din;
                mask[idx] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/plt_array.sv
module plt_array #(
    parameter int ADDR_W = 8,
    parameter int OFF_W  = 5
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  prog_en,
    input  logic [ADDR_W-OFF_W-1:0]               prog_page,
    input  logic [(1<<OFF_W)-1:0][plt_pkg::BYTE_W-1:0] prog_data,
    input  logic [(1<<OFF_W)-1:0]                 prog_mask,
    input  logic [ADDR_W-1:0]                     rd_addr,
    output logic [plt_pkg::BYTE_W-1:0]            rd_byte
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PB    = 1 << OFF_W;

    logic [plt_pkg::BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                cells[i] <= '0;
        end else if (prog_en) begin
            for (int i = 0; i < PB; i++)
                if (prog_mask[i])
                    cells[{prog_page, OFF_W'(i)}] <= prog_data[i];
        end
    end

    assign rd_byte = cells[rd_addr];
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl #(
    parameter int ADDR_W   = 8,
    parameter int OFF_W    = 5,
    parameter int LOAD_CYC = 20,
    parameter int PROG_CYC = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              wr_en_n_pin,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              commit
);
    import plt_pkg::*;

    localparam int PG_W = ADDR_W - OFF_W;
    localparam int PB   = 1 << OFF_W;

    plt_state_e state_q, state_d;
    logic [PG_W-1:0]           page_q;
    logic                      tog_q;
    logic                      wr_ok, same_pg, open_pg, add_byte;
    logic                      ld_zero, pg_zero, start_prog, finish;
    logic [PB-1:0][BYTE_W-1:0] buf_data;
    logic [PB-1:0]             buf_mask;
    logic [BYTE_W-1:0]         arr_byte;

    assign wr_ok      = wr_en && !wr_en_n_pin && (state_q != ST_PROG);
    assign same_pg    = (wr_addr[ADDR_W-1:OFF_W] == page_q);
    assign open_pg    = (state_q == ST_IDLE) && wr_ok;
    assign add_byte   = (state_q == ST_LOAD) && wr_ok && same_pg;
    assign start_prog = (state_q == ST_LOAD) && (state_d == ST_PROG);
    assign finish     = (state_q == ST_PROG) && pg_zero;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (open_pg) state_d = ST_LOAD;
            ST_LOAD: begin
                if (wr_en_n_pin)   state_d = ST_IDLE;
                else if (add_byte) state_d = ST_LOAD;
                else if (ld_zero)  state_d = ST_PROG;
            end
            ST_PROG: if (pg_zero) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            page_q  <= '0;
        end else begin
            state_q <= state_d;
            if (open_pg)
                page_q <= wr_addr[ADDR_W-1:OFF_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            commit  <= 1'b0;
            rd_data <= '0;
            tog_q   <= 1'b0;
        end else begin
            commit <= start_prog;
            if (state_q != ST_PROG)
                tog_q <= 1'b0;
            else if (rd_en)
                tog_q <= ~tog_q;
            if (rd_en) begin
                if (state_q == ST_PROG)
                    rd_data <= 8'(tog_q) << TOGGLE_BIT;
                else
                    rd_data <= arr_byte;
            end
        end
    end

    assign busy = (state_q == ST_PROG);

    plt_timer #(.LEN(LOAD_CYC)) i_load_tmr (
        .clk(clk), .rst_n(rst_n), .load(open_pg || add_byte),
        .dec(state_q == ST_LOAD), .zero(ld_zero)
    );

    plt_timer #(.LEN(PROG_CYC)) i_prog_tmr (
        .clk(clk), .rst_n(rst_n), .load(start_prog),
        .dec(state_q == ST_PROG), .zero(pg_zero)
    );

    plt_pagebuf #(.OFF_W(OFF_W)) i_buf (
        .clk(clk), .rst_n(rst_n), .clr(open_pg), .we(open_pg || add_byte),
        .idx(wr_addr[OFF_W-1:0]), .din(wr_data), .data(buf_data), .mask(buf_mask)
    );

    plt_array #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_array (
        .clk(clk), .rst_n(rst_n), .prog_en(finish), .prog_page(page_q),
        .prog_data(buf_data), .prog_mask(buf_mask), .rd_addr(rd_addr), .rd_byte(arr_byte)
    );

    AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) commit |=> !commit); // R2
    AST_COMMIT_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) commit |-> busy); // R2
    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_LOAD && state_d == ST_LOAD) |=> $stable(page_q)); // R3
    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n) (busy && rd_en) ##1 (busy && rd_en) |=> (rd_data[TOGGLE_BIT] != $past(rd_data[TOGGLE_BIT]))); // R5
    AST_STATUS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (busy && rd_en) |=> ((rd_data & 8'hBF) == 8'h00)); // R5
    AST_WC_ABORT: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_LOAD && wr_en_n_pin) |=> (state_q == ST_IDLE && !busy)); // R7
    AST_BUF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(buf_mask)); // R9
endmodule

// File: tb/test_page_load_ctrl.sv
`timescale 1ns/1ps
module test_page_load_ctrl;
    localparam int AW = 8, OW = 5, L = 12, P = 40;
    localparam int PB = 1 << OW, DEPTH = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 0, wr_en_n_pin = 0, rd_en = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic busy, commit;

    int checks = 0, errors = 0;
    logic [7:0] model [DEPTH];
    logic [7:0] pend_data [PB];
    bit pend_mask [PB];
    int pend_page = 0;

    always #2.5 clk = ~clk;

    page_load_ctrl #(.ADDR_W(AW), .OFF_W(OW), .LOAD_CYC(L), .PROG_CYC(P)) i_page_load_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_en_n_pin(wr_en_n_pin), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .commit(commit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1; wr_addr = AW'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic load_byte(input int a, input int d);
        wr(a, d);
        pend_mask[a % PB] = 1; pend_data[a % PB] = 8'(d); pend_page = a / PB;
    endtask

    task automatic clear_pend();
        for (int i = 0; i < PB; i++) pend_mask[i] = 0;
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        rd_en = 1; rd_addr = AW'(a);
        @(negedge clk);
        rd_en = 0; v = rd_data;
    endtask

    // waits from the negedge after the last accepted write (elapsed edges already spent)
    task automatic expect_start(input int elapsed, input string req);
        bit early = 0;
        for (int j = 0; j < L - 1 - elapsed; j++) begin
            @(negedge clk);
            if (busy) early = 1;
        end
        chk(!early, req, early, 0);
        @(negedge clk);
        chk(busy && commit, req, {busy, commit}, 3);
    endtask

    task automatic wait_done();
        while (busy) @(negedge clk);
        for (int i = 0; i < PB; i++)
            if (pend_mask[i]) model[pend_page * PB + i] = pend_data[i];
        clear_pend();
    endtask

    task automatic quiet(input int n, input string req);
        bit seen = 0;
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            if (busy || commit) seen = 1;
        end
        chk(!seen, req, seen, 0);
    endtask

    task automatic check_mem_all(input string req);
        logic [7:0] v;
        for (int a = 0; a < DEPTH; a++) begin
            rd(a, v);
            chk(v === model[a], req, v, model[a]);
        end
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        for (int a = 0; a < DEPTH; a++) model[a] = 8'h00;
        clear_pend();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(!busy && !commit && rd_data == 8'h00, "R11", {busy, commit, rd_data}, 0);
        check_mem_all("R11");

        // R1 R2 R4: full page 0, busy length, data visible right after busy falls
        for (int i = 0; i < PB; i++) load_byte(i, i * 7 + 3);
        expect_start(0, "R2");
        @(negedge clk);
        chk(!commit, "R2", commit, 0);
        n = 2;
        forever begin
            @(negedge clk);
            if (!busy) break;
            n++;
        end
        chk(n == P, "R4", n, P);
        rd(5, v);
        chk(v == 8'(5 * 7 + 3), "R4", v, 5 * 7 + 3);
        wait_done();
        check_mem_all("R1");

        // R2 retrigger: writes spaced L-2 apart keep the window open
        load_byte(PB + 1, 8'h11);
        quiet(L - 2, "R2");
        load_byte(PB + 2, 8'h22);
        quiet(L - 2, "R2");
        load_byte(PB + 3, 8'h33);
        expect_start(0, "R2");
        wait_done();

        // R5 toggle status during busy
        load_byte(2 * PB + 4, 8'hFF);
        load_byte(2 * PB + 9, 8'h0F);
        expect_start(0, "R5");
        rd_en = 1; rd_addr = AW'(2 * PB + 4);
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            chk(rd_data == ((j % 2) ? 8'h40 : 8'h00), "R5", rd_data, (j % 2) ? 8'h40 : 8'h00);
        end
        rd_en = 0;
        wait_done();
        // R6 hold between reads
        rd(2 * PB + 4, v);
        repeat (3) @(negedge clk);
        chk(rd_data == 8'hFF, "R6", rd_data, 8'hFF);
        check_mem_all("R6");

        // R10 partial overwrite of page 0, last write wins
        load_byte(3, 8'hA3);
        load_byte(10, 8'h01);
        load_byte(10, 8'hB0);
        expect_start(0, "R10");
        wait_done();
        check_mem_all("R10");

        // R3 off-page write ignored and does not restart window
        load_byte(3 * PB, 8'h77);
        repeat (4) @(negedge clk);
        wr(4 * PB + 6, 8'h99);
        expect_start(5, "R3");
        wait_done();
        check_mem_all("R3");

        // R7 cancel by pin during load
        load_byte(5 * PB + 1, 8'h55);
        load_byte(5 * PB + 2, 8'h56);
        repeat (3) @(negedge clk);
        wr_en_n_pin = 1;
        @(negedge clk);
        wr_en_n_pin = 0;
        clear_pend();
        quiet(2 * L, "R7");
        check_mem_all("R7");

        // R8 pin held high blocks writes
        wr_en_n_pin = 1;
        wr(6 * PB, 8'h66);
        wr(6 * PB + 1, 8'h67);
        quiet(2 * L, "R8");
        wr_en_n_pin = 0;
        check_mem_all("R8");

        // R9 writes during busy discarded
        load_byte(7 * PB + 8, 8'hC8);
        expect_start(0, "R9");
        wr(6 * PB + 4, 8'hEE);
        wr(7 * PB + 9, 8'hEF);
        wait_done();
        quiet(2 * L, "R9");
        check_mem_all("R9");

        // R1 R10 sweep over every page with a sparse pattern
        for (int pg = 0; pg < DEPTH / PB; pg++) begin
            for (int i = 0; i < PB; i++)
                if ((i + pg) % 3 != 0) load_byte(pg * PB + i, (pg * 37 + i * 11) ^ 8'h5A);
            expect_start(0, "R1");
            wait_done();
        end
        check_mem_all("R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule